// File: doc/BRIEF.md
# Inter-core interrupt generator

This block lets any core in a cluster raise an interrupt on any other core, and it lets the interrupted core find out who raised it. Every core owns a command slot: a valid bit, a 3-bit command code and a core-number field. The core-number field names the target for raise and query commands, and the sender for clear commands. The issuing core's ID is the index of the slot. The block holds a pending matrix indexed by receiver and sender. Each core has one interrupt line, which is the OR of its row of that matrix. Each core also has a readback register that returns the result of its last query or source-mask command.

Commands are split into two lanes. Raise and query commands go to a sender-side lane, and source-mask and clear commands go to a receiver-side lane. Each lane has its own fixed-priority arbiter, and the lower core number wins. A core that is not granted keeps its request up until it is served. Because the two lanes are separate, a raise and a clear can reach the same pending bit in one cycle. In that case the raise wins.

Top module: `ipi_gen_top`

## Requirements
- R1: After reset every interrupt line, every readback register and every grant is zero.
- R2: A granted raise (code 1) from core s to target t sets pending bit (t,s). irq_o[t] is high in the cycle after the command.
- R3: A raise whose target equals its issuer is ignored. No interrupt line changes, and the issuer's source mask stays unchanged.
- R4: A granted query (code 2) naming target t loads the issuer's readback with 1 in bit 0 if t has any pending bit, and 0 otherwise. The value is visible in the cycle after the command.
- R5: A granted source-mask command (code 3) loads the issuer's readback with its pending row. Bit n is set when core n has an interrupt pending at the issuer.
- R6: Raises from several senders to one target drive the single line irq_o[t], and the source mask then has several bits set.
- R7: A granted clear (code 4) from core r naming sender s clears only pending bit (r,s). The line stays high while other bits in the row are set.
- R8: irq_o[r] is still high in the cycle of the clear that removes the last pending bit, and low in the cycle after.
- R9: If a raise and a clear hit the same pending bit in the same cycle, the bit stays set.
- R10: Within one lane, the lowest-numbered requesting core is granted. grant_o shows the winner in the same cycle, and a losing request is served in a later cycle.
- R11: A raise or query and a source-mask or clear from different cores are both granted in the same cycle. Codes 0, 5, 6 and 7 are never granted and have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | N_CORES | Per-core command valid |
| req_cmd_i | input | N_CORES*3 | Per-core command code, core i in bits [3i+2:3i] |
| req_core_i | input | N_CORES*ID_W | Per-core target or sender number |
| grant_o | output | N_CORES | Per-core command accepted this cycle |
| irq_o | output | N_CORES | Per-core interrupt line |
| rdata_o | output | N_CORES*N_CORES | Per-core readback register, core i in bits [N*i+N-1:N*i] |

## Verification
The walked table applies single commands in sequences that tell the cases apart. One sequence has one sender to a target, then two senders coalescing onto one line, then clears in both orders. Another has a self-raise mixed in among valid raises, and queries of busy and idle targets, so a readback that returns the wrong row or a stale value shows up. Directed tests then press two requests on one lane at once to expose the priority order. They also drive one raise and one clear on both lanes into the same bit, which separates set-wins from clear-wins. They check the line in the clearing cycle and in the cycle after, which catches an off-by-one in the drop timing.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int unsigned CMD_W = 3;
  typedef enum logic [CMD_W-1:0] {
    CMD_IDLE  = 3'd0,
    CMD_RAISE = 3'd1,
    CMD_QUERY = 3'd2,
    CMD_SRCS  = 3'd3,
    CMD_CLEAR = 3'd4
  } ipi_cmd_e;
endpackage

// File: rtl/ipi_arb.sv
module ipi_arb #(
  parameter int unsigned N    = 4,
  parameter int unsigned ID_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N-1:0]    req_i,
  output logic [N-1:0]    gnt_o,
  output logic [ID_W-1:0] idx_o,
  output logic            any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = ID_W'(i);
    end
    any_o = |req_i;
    gnt_o = any_o ? (N'(1) << idx_o) : '0;
  end

  a_r10_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(gnt_o));

  for (genvar g = 1; g < N; g++) begin : g_prio
    a_r10_lowest: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gnt_o[g] |-> (req_i[g-1:0] == '0));
  end
endmodule

// File: rtl/ipi_matrix.sv
module ipi_matrix #(
  parameter int unsigned N    = 4,
  parameter int unsigned ID_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                set_en_i,
  input  logic [ID_W-1:0]     set_recv_i,
  input  logic [ID_W-1:0]     set_send_i,
  input  logic                clr_en_i,
  input  logic [ID_W-1:0]     clr_recv_i,
  input  logic [ID_W-1:0]     clr_send_i,
  output logic [N-1:0][N-1:0] pend_o,
  output logic [N-1:0]        irq_o
);
  logic [N-1:0][N-1:0] pend_q;

  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar s = 0; s < N; s++) begin : g_col
      logic set_hit, clr_hit;
      assign set_hit = set_en_i && (set_recv_i == ID_W'(r)) && (set_send_i == ID_W'(s))
                       && (r != s);
      assign clr_hit = clr_en_i && (clr_recv_i == ID_W'(r)) && (clr_send_i == ID_W'(s));

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      pend_q[r][s] <= 1'b0;
        else if (set_hit) pend_q[r][s] <= 1'b1;  // set beats clear
        else if (clr_hit) pend_q[r][s] <= 1'b0;
      end

      a_r2_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_hit |=> pend_q[r][s]);
      a_r9_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (set_hit && clr_hit) |=> pend_q[r][s]);
      a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_hit && !set_hit) |=> !pend_q[r][s]);
    end
    assign irq_o[r] = |pend_q[r];

    a_r3_no_self: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pend_q[r][r]);
    a_r8_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(irq_o[r]) |-> $past(clr_en_i && clr_recv_i == ID_W'(r)));
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/ipi_readback.sv
module ipi_readback #(
  parameter int unsigned N    = 4,
  parameter int unsigned ID_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                qry_en_i,
  input  logic [ID_W-1:0]     qry_issuer_i,
  input  logic [ID_W-1:0]     qry_target_i,
  input  logic                src_en_i,
  input  logic [ID_W-1:0]     src_issuer_i,
  input  logic [N-1:0][N-1:0] pend_i,
  output logic [N-1:0][N-1:0] rd_o
);
  logic [N-1:0][N-1:0] rd_q;

  for (genvar c = 0; c < N; c++) begin : g_core
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rd_q[c] <= '0;
      else if (qry_en_i && qry_issuer_i == ID_W'(c))
        rd_q[c] <= N'(|pend_i[qry_target_i]);
      else if (src_en_i && src_issuer_i == ID_W'(c))
        rd_q[c] <= pend_i[c];
    end
  end

  a_r5_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_en_i |=> rd_q[$past(src_issuer_i)] == $past(pend_i[src_issuer_i]));
  a_r4_qry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qry_en_i |=> rd_q[$past(qry_issuer_i)][N-1:1] == '0);

  assign rd_o = rd_q;
endmodule

// File: rtl/ipi_gen_top.sv
module ipi_gen_top #(
  parameter int unsigned N_CORES = 4,
  parameter int unsigned ID_W    = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [N_CORES-1:0]           req_valid_i,
  input  logic [N_CORES*3-1:0]         req_cmd_i,
  input  logic [N_CORES*ID_W-1:0]      req_core_i,
  output logic [N_CORES-1:0]           grant_o,
  output logic [N_CORES-1:0]           irq_o,
  output logic [N_CORES*N_CORES-1:0]   rdata_o
);
  import ipi_pkg::*;
  localparam int unsigned CW = CMD_W;

  logic [CW-1:0]   cmd_w  [N_CORES];
  logic [ID_W-1:0] core_w [N_CORES];
  logic [N_CORES-1:0] req_a, req_b, gnt_a, gnt_b;
  logic [ID_W-1:0] idx_a, idx_b;
  logic any_a, any_b;

  for (genvar i = 0; i < N_CORES; i++) begin : g_dec
    assign cmd_w[i]  = req_cmd_i[i*CW +: CW];
    assign core_w[i] = req_core_i[i*ID_W +: ID_W];
    assign req_a[i]  = req_valid_i[i] &&
                       (cmd_w[i] == CMD_RAISE || cmd_w[i] == CMD_QUERY);
    assign req_b[i]  = req_valid_i[i] &&
                       (cmd_w[i] == CMD_SRCS || cmd_w[i] == CMD_CLEAR);
  end

  // sender-side lane: raise, query
  ipi_arb #(.N(N_CORES), .ID_W(ID_W)) u_arb_a (
    .clk_i, .rst_ni, .req_i(req_a), .gnt_o(gnt_a), .idx_o(idx_a), .any_o(any_a)
  );
  // receiver-side lane: source mask, clear
  ipi_arb #(.N(N_CORES), .ID_W(ID_W)) u_arb_b (
    .clk_i, .rst_ni, .req_i(req_b), .gnt_o(gnt_b), .idx_o(idx_b), .any_o(any_b)
  );

  logic set_en, qry_en, clr_en, src_en;
  assign set_en = any_a && cmd_w[idx_a] == CMD_RAISE;
  assign qry_en = any_a && cmd_w[idx_a] == CMD_QUERY;
  assign clr_en = any_b && cmd_w[idx_b] == CMD_CLEAR;
  assign src_en = any_b && cmd_w[idx_b] == CMD_SRCS;

  logic [N_CORES-1:0][N_CORES-1:0] pend, rd;

  ipi_matrix #(.N(N_CORES), .ID_W(ID_W)) u_matrix (
    .clk_i, .rst_ni,
    .set_en_i(set_en), .set_recv_i(core_w[idx_a]), .set_send_i(idx_a),
    .clr_en_i(clr_en), .clr_recv_i(idx_b), .clr_send_i(core_w[idx_b]),
    .pend_o(pend), .irq_o(irq_o)
  );

  ipi_readback #(.N(N_CORES), .ID_W(ID_W)) u_rb (
    .clk_i, .rst_ni,
    .qry_en_i(qry_en), .qry_issuer_i(idx_a), .qry_target_i(core_w[idx_a]),
    .src_en_i(src_en), .src_issuer_i(idx_b),
    .pend_i(pend), .rd_o(rd)
  );

  assign grant_o = gnt_a | gnt_b;
  assign rdata_o = rd;

  a_r11_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_a & gnt_b) == '0);
  a_r11_no_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o & ~req_valid_i) == '0);
endmodule

// File: tb/tb_ipi_gen_top.sv
`timescale 1ns/1ps
module tb_ipi_gen_top;
  localparam int N = 4;
  localparam int IW = 2;

  logic clk = 0, rst_n = 0;
  logic [N-1:0]    req_valid;
  logic [N*3-1:0]  req_cmd;
  logic [N*IW-1:0] req_core;
  logic [N-1:0]    grant, irq;
  logic [N*N-1:0]  rdata;

  always #2 clk = ~clk;

  ipi_gen_top #(.N_CORES(N)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_cmd_i(req_cmd),
    .req_core_i(req_core), .grant_o(grant), .irq_o(irq), .rdata_o(rdata)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic put(int c, logic [2:0] cmd, logic [1:0] core);
    req_valid[c] = 1'b1;
    req_cmd[c*3 +: 3] = cmd;
    req_core[c*IW +: IW] = core;
  endtask

  task automatic idle_all();
    req_valid = '0; req_cmd = '0; req_core = '0;
  endtask

  // {issuer, cmd, core, exp irq, exp issuer readback}
  localparam logic [14:0] VEC [14] = '{
    {2'd1, 3'd1, 2'd2, 4'h4, 4'h0},  // R2 c1 raises c2
    {2'd0, 3'd2, 2'd2, 4'h4, 4'h1},  // R4 query busy target
    {2'd3, 3'd1, 2'd2, 4'h4, 4'h0},  // R6 second sender to c2
    {2'd2, 3'd3, 2'd0, 4'h4, 4'hA},  // R6 mask has bits 1 and 3
    {2'd2, 3'd4, 2'd1, 4'h4, 4'hA},  // R7 clear sender 1 only
    {2'd2, 3'd3, 2'd0, 4'h4, 4'h8},  // R7 sender 3 remains
    {2'd0, 3'd2, 2'd1, 4'h4, 4'h0},  // R4 query idle target
    {2'd1, 3'd1, 2'd1, 4'h4, 4'h0},  // R3 self raise ignored
    {2'd1, 3'd3, 2'd0, 4'h4, 4'h0},  // R3 no self bit
    {2'd2, 3'd4, 2'd3, 4'h0, 4'h8},  // R8 last clear drops line
    {2'd0, 3'd2, 2'd2, 4'h0, 4'h0},  // R4 query after drop
    {2'd3, 3'd1, 2'd0, 4'h1, 4'h0},  // R2 c3 raises c0
    {2'd0, 3'd3, 2'd0, 4'h1, 4'h8},  // R5 source mask
    {2'd0, 3'd4, 2'd3, 4'h0, 4'h8}   // R7 clear
  };

  function automatic string tag(logic [2:0] c);
    case (c)
      3'd1: return "R2";
      3'd2: return "R4";
      3'd3: return "R5";
      default: return "R7";
    endcase
  endfunction

  initial begin
    idle_all();
    repeat (3) @(negedge clk);
    chk("R1 irq", 16'(irq), 16'h0);
    chk("R1 rdata", 16'(rdata), 16'h0);
    chk("R1 grant", 16'(grant), 16'h0);
    rst_n = 1;
    @(negedge clk);

    for (int k = 0; k < 14; k++) begin
      automatic int iss = int'(VEC[k][14:13]);
      put(iss, VEC[k][12:10], VEC[k][9:8]);
      @(negedge clk);
      idle_all();
      chk(tag(VEC[k][12:10]), 16'(irq), 16'(VEC[k][7:4]));
      chk(tag(VEC[k][12:10]), 16'(rdata[iss*N +: N]), 16'(VEC[k][3:0]));
    end

    // R10: c1 and c3 raise c0 together; c1 wins first
    put(1, 3'd1, 2'd0); put(3, 3'd1, 2'd0);
    #1 chk("R10 grant", 16'(grant), 16'h2);
    @(negedge clk);
    req_valid[1] = 1'b0;
    #1 chk("R10 grant later", 16'(grant), 16'h8);
    @(negedge clk);
    idle_all();
    put(0, 3'd3, 2'd0);
    @(negedge clk);
    idle_all();
    chk("R10 both served", 16'(rdata[3:0]), 16'hA);

    // R8: line high during final clears, low after
    put(0, 3'd4, 2'd1);
    @(negedge clk);
    idle_all();
    put(0, 3'd4, 2'd3);
    #1 chk("R8 high in clear cycle", 16'(irq[0]), 16'h1);
    @(negedge clk);
    idle_all();
    chk("R8 low after", 16'(irq[0]), 16'h0);

    // R9/R11: raise and clear of bit (2,0) in one cycle
    put(0, 3'd1, 2'd2);
    @(negedge clk);
    idle_all();
    put(0, 3'd1, 2'd2); put(2, 3'd4, 2'd0);
    #1 chk("R11 dual grant", 16'(grant), 16'h5);
    @(negedge clk);
    idle_all();
    chk("R9 line held", 16'(irq), 16'h4);
    put(2, 3'd3, 2'd0);
    @(negedge clk);
    idle_all();
    chk("R9 bit kept", 16'(rdata[11:8]), 16'h1);

    // R11: undefined codes ignored
    put(1, 3'd5, 2'd0); put(3, 3'd7, 2'd2);
    #1 chk("R11 no grant", 16'(grant), 16'h0);
    @(negedge clk);
    idle_all();
    chk("R11 irq unchanged", 16'(irq), 16'h4);
    chk("R11 rdata unchanged", 16'(rdata[15:12]), 16'h0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule